// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit forms a physical byte address from a segment register and a 16-bit offset. A protection-enable input picks one of two modes. In real mode each segment register holds a paragraph number, so the address is the segment value shifted left by four plus the offset. A 1 MB gate input decides whether bit 20 of that sum is kept or dropped. When it is dropped, addresses above 1 MB wrap back to the bottom of memory.

In protected mode a write to a segment register loads a selector. A three-state sequencer then reads the 8-byte descriptor from the global table through a 32-bit read port with a valid/ready handshake. It takes the two words, decodes base and limit, and stores them in a per-segment cache. Later accesses add the offset to the cached base without reading the table again. Two faults exist. A selector fault is raised for an access through a segment with no valid cache entry, which covers a null selector, a local-table selector and a segment never loaded. A limit fault is raised for an offset beyond the cached limit.

The sequencer states are F_IDLE, F_LO and F_HI. F_IDLE goes to F_LO on a protected-mode write of a fetchable selector. F_LO goes to F_HI when the low-word read is accepted. F_HI goes to F_IDLE when the high-word read is accepted, and the cache is written on that same edge. Each of F_LO and F_HI waits in place while the read port is not ready.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset the unit is idle (busy and rd_valid low), every segment register is zero, and in real mode phys_addr equals the offset.
- R2: In real mode with a20_en=1, phys_addr = seg*16 + off with up to 21 significant bits; segment F800 with offset 8000 gives 0x100000.
- R3: In real mode with a20_en=0, bit 20 of the sum is forced to zero, so F800:8000 gives 0x00000.
- R4: In protected mode, a write of a selector with bit 2 = 0 and bits 15..3 nonzero starts a fetch. In the next cycle rd_valid rises with rd_addr = gdt_base + (selector with bits 2..0 cleared). After that read is accepted, a second read follows at that address + 4. busy is high from the cycle after the write until the edge that accepts the second read.
- R5: While rd_valid is high and rd_ready is low, rd_valid stays high and rd_addr holds its value.
- R6: The descriptor is decoded little-endian from the two words. The first word gives limit[15:0] in bits 15..0 and base[15:0] in bits 31..16. The second word gives base[23:16] in bits 7..0, limit[19:16] in bits 19..16 and base[31:24] in bits 31..24, while bits 15..8 (access byte) are unused. A valid protected access gives phys_addr = base + off modulo 2^32.
- R7: fault_limit is high for a valid protected access exactly when off > limit; off == limit does not fault.
- R8: A protected-mode write of a null selector (bits 15..2 all zero) or of a selector with bit 2 = 1 starts no read and leaves that segment invalid. Any protected access through an invalid segment, including any segment after reset, raises fault_sel.
- R9: Segment register writes presented while busy is high are ignored.
- R10: A loaded cache entry is reused with no further reads, and it survives leaving and re-entering protected mode.
- R11: Faults are only raised when acc_valid is high and pe_en is high; in real mode both faults stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pe_en | input | 1 | Protection enable: 1 protected, 0 real |
| a20_en | input | 1 | 1 keeps address bit 20 in real mode |
| gdt_base | input | 32 | Global descriptor table base address |
| seg_wr | input | 1 | Segment register write strobe |
| seg_wr_idx | input | 2 | Segment register to write |
| seg_wr_val | input | 16 | Paragraph number or selector |
| acc_valid | input | 1 | An access is presented |
| acc_seg | input | 2 | Segment used by the access |
| acc_off | input | 16 | Offset of the access |
| phys_addr | output | 32 | Physical byte address |
| fault_sel | output | 1 | Access through an invalid segment |
| fault_limit | output | 1 | Offset beyond cached limit |
| busy | output | 1 | Descriptor fetch in progress |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 32 | Read word address |
| rd_ready | input | 1 | Read accepted; rd_data valid |
| rd_data | input | 32 | Read data word |

## Verification
A wrong segment value or 1 MB gate handling shows up on phys_addr in the same cycle as the access. A bad sequencer state shows within one cycle as a wrong rd_valid, rd_addr or busy level. A mis-decoded or misplaced cache entry is visible on the first protected access after the fetch completes, either as a wrong base sum or as a fault at the wrong offset. The bench model predicts every port each cycle, so any divergence is flagged in the cycle where it first appears.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int SEG_W  = 16;
    localparam int OFF_W  = 16;
    localparam int ADDR_W = 32;
    localparam int LIM_W  = 20;
    localparam int REAL_W = SEG_W + 5;

    typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fetch_st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
    } desc_t;
endpackage

// File: rtl/seg_fetch_fsm.sv
module seg_fetch_fsm
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [31:0]       rd_data,
    output logic              busy,
    output logic              done,
    output desc_t             desc
);
    fetch_st_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= F_IDLE;
            addr_q  <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (start && state_q == F_IDLE) addr_q <= start_addr;
            if (state_q == F_LO && rd_ready) lo_q <= rd_data;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_IDLE: if (start)    state_d = F_LO;
            F_LO:   if (rd_ready) state_d = F_HI;
            F_HI:   if (rd_ready) state_d = F_IDLE;
            default:              state_d = F_IDLE;
        endcase
    end

    always_comb begin
        rd_valid   = (state_q != F_IDLE);
        rd_addr    = (state_q == F_HI) ? addr_q + 32'd4 : addr_q;
        busy       = rd_valid;
        done       = (state_q == F_HI) && rd_ready;
        desc.limit = {rd_data[19:16], lo_q[15:0]};
        desc.base  = {rd_data[31:24], rd_data[7:0], lo_q[31:16]};
    end

    // R5: a stalled request keeps its address
    a_r5_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    // R4: second word follows the first at +4
    a_r4_second_word: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == F_LO && rd_ready |=> rd_addr == $past(rd_addr) + 32'd4);
endmodule

// File: rtl/seg_state.sv
module seg_state
    import seg_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int IDX_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEG_W-1:0] wr_val,
    input  logic             wr_inval,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  desc_t            fill_desc,
    input  logic             busy,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [SEG_W-1:0] rd_seg,
    output desc_t            rd_desc,
    output logic             rd_vld
);
    logic [NSEG-1:0][SEG_W-1:0] seg_q;
    desc_t                      cache_q [NSEG];
    logic [NSEG-1:0]            vld_q;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[g]   <= '0;
                cache_q[g] <= '0;
                vld_q[g]   <= 1'b0;
            end else begin
                if (wr_en && wr_idx == IDX_W'(g)) begin
                    seg_q[g] <= wr_val;
                    if (wr_inval) vld_q[g] <= 1'b0;
                end
                if (fill_en && fill_idx == IDX_W'(g)) begin
                    cache_q[g] <= fill_desc;
                    vld_q[g]   <= 1'b1;
                end
            end
        end
    end

    assign rd_seg  = seg_q[rd_idx];
    assign rd_desc = cache_q[rd_idx];
    assign rd_vld  = vld_q[rd_idx];

    // R9: registers frozen while a fetch runs
    a_r9_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(seg_q));

    // R10: an entry only becomes valid through a completed fetch
    a_r10_fill_only: assert property (@(posedge clk) disable iff (!rst_n)
        (|(vld_q & ~$past(vld_q))) |-> $past(fill_en));
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
    import seg_pkg::*;
(
    input  logic              pe_en,
    input  logic              a20_en,
    input  logic              acc_valid,
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    input  desc_t             desc,
    input  logic              vld,
    output logic [ADDR_W-1:0] phys,
    output logic              fault_sel,
    output logic              fault_lim
);
    logic [REAL_W-1:0] real_sum;
    logic [REAL_W-1:0] real_addr;

    always_comb begin
        real_sum  = {1'b0, seg, 4'b0000} + REAL_W'(off);
        real_addr = real_sum;
        real_addr[20] = real_sum[20] & a20_en;
        if (pe_en) begin
            phys      = desc.base + ADDR_W'(off);
            fault_sel = acc_valid && !vld;
            fault_lim = acc_valid && vld && (LIM_W'(off) > desc.limit);
        end else begin
            phys      = ADDR_W'(real_addr);
            fault_sel = 1'b0;
            fault_lim = 1'b0;
        end
    end
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
    import seg_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int IDX_W = $clog2(NSEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pe_en,
    input  logic              a20_en,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic              seg_wr,
    input  logic [IDX_W-1:0]  seg_wr_idx,
    input  logic [SEG_W-1:0]  seg_wr_val,
    input  logic              acc_valid,
    input  logic [IDX_W-1:0]  acc_seg,
    input  logic [OFF_W-1:0]  acc_off,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              fault_sel,
    output logic              fault_limit,
    output logic              busy,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [31:0]       rd_data
);
    logic             wr_ok, fetchable, start, done;
    logic [IDX_W-1:0] tgt_q;
    desc_t            fetched, cur_desc;
    logic [SEG_W-1:0] cur_seg;
    logic             cur_vld;

    assign wr_ok     = seg_wr && !busy;
    assign fetchable = !seg_wr_val[2] && (|seg_wr_val[15:3]);
    assign start     = wr_ok && pe_en && fetchable;

    always_ff @(posedge clk) begin
        if (!rst_n)     tgt_q <= '0;
        else if (start) tgt_q <= seg_wr_idx;
    end

    seg_fetch_fsm i_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (gdt_base + {seg_wr_val[15:3], 3'b000}),
        .rd_valid   (rd_valid),
        .rd_addr    (rd_addr),
        .rd_ready   (rd_ready),
        .rd_data    (rd_data),
        .busy       (busy),
        .done       (done),
        .desc       (fetched)
    );

    seg_state #(.NSEG(NSEG), .IDX_W(IDX_W)) i_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok),
        .wr_idx    (seg_wr_idx),
        .wr_val    (seg_wr_val),
        .wr_inval  (pe_en),
        .fill_en   (done),
        .fill_idx  (tgt_q),
        .fill_desc (fetched),
        .busy      (busy),
        .rd_idx    (acc_seg),
        .rd_seg    (cur_seg),
        .rd_desc   (cur_desc),
        .rd_vld    (cur_vld)
    );

    seg_addr_calc i_calc (
        .pe_en     (pe_en),
        .a20_en    (a20_en),
        .acc_valid (acc_valid),
        .seg       (cur_seg),
        .off       (acc_off),
        .desc      (cur_desc),
        .vld       (cur_vld),
        .phys      (phys_addr),
        .fault_sel (fault_sel),
        .fault_lim (fault_limit)
    );

    // R3: gated real-mode addresses stay below 1 MB
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_en && !a20_en |-> phys_addr[ADDR_W-1:20] == '0);

    // R11: no fault in real mode or without an access
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(pe_en && acc_valid) |-> !fault_sel && !fault_limit);

    // R8: a null selector write never starts a read
    a_r8_null_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && seg_wr && seg_wr_val[15:2] == '0 |=> !rd_valid);

    // R4: a fetchable write in protected mode raises rd_valid next cycle
    a_r4_launch: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && seg_wr && pe_en && !seg_wr_val[2] && seg_wr_val[15:3] != '0
        |=> rd_valid && busy);
endmodule

// File: tb/test_seg_addr_unit.sv
module test_seg_addr_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pe_en = 1'b0, a20_en = 1'b0;
    logic [31:0] gdt_base = 32'h0002_0000;
    logic        seg_wr = 1'b0;
    logic [1:0]  seg_wr_idx = '0;
    logic [15:0] seg_wr_val = '0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_seg = '0;
    logic [15:0] acc_off = '0;
    logic [31:0] phys_addr, rd_addr;
    logic        fault_sel, fault_limit, busy, rd_valid;
    logic        rd_ready = 1'b1;
    logic [31:0] rd_data = '0;

    int checks = 0, fails = 0, cyc = 0, rdy_mode = 0;

    logic [31:0] dmem [logic [31:0]];
    int          phase = 0, m_tgt = 0;
    logic [15:0] m_seg [4];
    bit          m_vld [4];
    logic [31:0] m_base [4];
    logic [19:0] m_lim [4];
    logic [31:0] m_daddr = '0, m_lo = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_addr_unit i_seg_addr_unit (
        .clk(clk), .rst_n(rst_n), .pe_en(pe_en), .a20_en(a20_en),
        .gdt_base(gdt_base), .seg_wr(seg_wr), .seg_wr_idx(seg_wr_idx),
        .seg_wr_val(seg_wr_val), .acc_valid(acc_valid), .acc_seg(acc_seg),
        .acc_off(acc_off), .phys_addr(phys_addr), .fault_sel(fault_sel),
        .fault_limit(fault_limit), .busy(busy), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data)
    );

    function automatic logic [31:0] memrd(input logic [31:0] a);
        return dmem.exists(a) ? dmem[a] : 32'h0;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic put_desc(input int idx, input logic [31:0] b,
                            input logic [19:0] l);
        logic [31:0] a;
        a = gdt_base + 32'(idx) * 8;
        dmem[a]     = {b[15:0], l[15:0]};
        dmem[a + 4] = {b[31:24], 4'h0, l[19:16], 8'h9A, b[23:16]};
    endtask

    task automatic compare(input string tag);
        logic [20:0] r;
        int s;
        s = int'(acc_seg);
        chk(tag, "busy", {31'b0, busy}, {31'b0, phase != 0});
        chk(tag, "rd_valid", {31'b0, rd_valid}, {31'b0, phase != 0});
        if (phase != 0)
            chk(tag, "rd_addr", rd_addr, phase == 1 ? m_daddr : m_daddr + 4);
        if (!pe_en) begin
            r = {1'b0, m_seg[s], 4'b0} + {5'b0, acc_off};
            if (!a20_en) r[20] = 1'b0;
            chk(tag, "phys real", phys_addr, {11'b0, r});
            chk(tag, "fault_sel", {31'b0, fault_sel}, 32'h0);
            chk(tag, "fault_limit", {31'b0, fault_limit}, 32'h0);
        end else begin
            chk(tag, "fault_sel", {31'b0, fault_sel},
                {31'b0, acc_valid && !m_vld[s]});
            chk(tag, "fault_limit", {31'b0, fault_limit},
                {31'b0, acc_valid && m_vld[s] && ({4'b0, acc_off} > m_lim[s])});
            if (m_vld[s])
                chk(tag, "phys prot", phys_addr, m_base[s] + {16'b0, acc_off});
        end
    endtask

    task automatic model_edge();
        logic [31:0] hi;
        int i;
        i = int'(seg_wr_idx);
        if (phase == 0) begin
            if (seg_wr) begin
                m_seg[i] = seg_wr_val;
                if (pe_en) begin
                    m_vld[i] = 1'b0;
                    if (!seg_wr_val[2] && seg_wr_val[15:3] != 0) begin
                        phase   = 1;
                        m_tgt   = i;
                        m_daddr = gdt_base + {16'b0, seg_wr_val[15:3], 3'b0};
                    end
                end
            end
        end else if (rd_ready) begin
            if (phase == 1) begin
                m_lo  = memrd(m_daddr);
                phase = 2;
            end else begin
                hi = memrd(m_daddr + 4);
                m_base[m_tgt] = {hi[31:24], hi[7:0], m_lo[31:16]};
                m_lim[m_tgt]  = {hi[19:16], m_lo[15:0]};
                m_vld[m_tgt]  = 1'b1;
                phase = 0;
            end
        end
    endtask

    task automatic step(input string tag);
        rd_ready = (rdy_mode == 0) ? 1'b1 : (cyc % 3 == 2);
        #1;
        rd_data = rd_valid ? memrd(rd_addr) : 32'h0;
        compare(tag);
        @(posedge clk);
        if (rst_n) model_edge();
        cyc++;
        @(negedge clk);
    endtask

    task automatic wseg(input logic [1:0] i, input logic [15:0] v, input string tag);
        seg_wr = 1'b1; seg_wr_idx = i; seg_wr_val = v;
        step(tag);
        seg_wr = 1'b0;
    endtask

    task automatic acc(input logic [1:0] s, input logic [15:0] o, input string tag);
        acc_valid = 1'b1; acc_seg = s; acc_off = o;
        step(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            m_seg[k] = '0; m_vld[k] = 1'b0; m_base[k] = '0; m_lim[k] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        acc(2'd0, 16'h1234, "R1");
        acc(2'd3, 16'hFFFF, "R1");
        // R3 and R2: gated and ungated wraparound
        wseg(2'd0, 16'hF800, "R3");
        acc(2'd0, 16'h8000, "R3");
        a20_en = 1'b1;
        acc(2'd0, 16'h8000, "R2");
        wseg(2'd1, 16'h1234, "R2");
        acc(2'd1, 16'h5678, "R2");
        a20_en = 1'b0;
        acc(2'd1, 16'h5678, "R3");
        // descriptor table
        put_desc(2, 32'h1234_5678, 20'h00FFF);
        put_desc(5, 32'h8000_0000, 20'h1FFFF);
        put_desc(7, 32'hFFFF_FFF0, 20'h0FFFF);
        // R8: unloaded segments fault after entering protected mode
        pe_en = 1'b1;
        acc(2'd2, 16'h0010, "R8");
        // R4 R5: fetch with stalls; R9: write during fetch ignored
        rdy_mode = 1;
        wseg(2'd1, 16'h0013, "R4");
        wseg(2'd2, 16'h0028, "R9");
        idle(8, "R5");
        rdy_mode = 0;
        acc(2'd2, 16'h0000, "R9");
        // R6 R7: base sum and limit edge
        acc(2'd1, 16'h0FFF, "R7");
        acc(2'd1, 16'h1000, "R7");
        acc(2'd1, 16'h0042, "R6");
        // second descriptor, no stall
        wseg(2'd2, 16'h0028, "R4");
        idle(3, "R4");
        acc(2'd2, 16'hFFFF, "R6");
        wseg(2'd3, 16'h0038, "R4");
        idle(3, "R4");
        acc(2'd3, 16'h0020, "R6");
        // R8: null and local-table selectors
        wseg(2'd3, 16'h0003, "R8");
        acc(2'd3, 16'h0001, "R8");
        wseg(2'd2, 16'h0014, "R8");
        acc(2'd2, 16'h0001, "R8");
        // R11: no access presented, and real mode
        acc_valid = 1'b0;
        step("R11");
        pe_en = 1'b0;
        acc(2'd1, 16'hFFFF, "R11");
        // R10: cache survives a mode round trip, no reads
        pe_en = 1'b1;
        acc(2'd1, 16'h0100, "R10");
        idle(3, "R10");
        acc(2'd1, 16'h2000, "R10");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule